// File: doc/BRIEF.md
# SMM Entry Save and Reinitialisation Sequencer

This block carries a processor core from the moment a pending system-management interrupt is accepted up to the point where the core's registers hold their defined management-mode entry values. When a request is taken in the idle state, the block latches the save-region base and a parallel snapshot of the architectural registers. It raises its acknowledge output and walks the whole 512-byte save region from its top word downwards. Each step is one 32-bit write on a single-port memory interface that is throttled by a ready input.

After the last word has been accepted, the block issues a single load strobe together with the entry values. The code segment gets selector 3000h and base 0003_0000h. The data, extra and stack segments get selector and base zero, a 4 GB limit and 16-bit expand-up attributes. The flags become 2, the instruction pointer becomes 8000h, control register 4 becomes zero, and control register 0 has its protection-enable, emulation, task-switched and paging bits cleared. A done pulse follows one cycle later. Registers that keep their values on entry get no load output.

Top module: `smm_entry_seq`

## Requirements
- R1: `smiact` goes high on the first clock edge after a request is accepted in idle. It stays high through every save write, the load cycle and the done cycle, and is low in the cycle after `done`.
- R2: Every save write drives `mem_be` = 4'b1111, and the first write of an entry goes to base + FFFCh.
- R3: Each accepted write lowers `mem_addr` by 4. There are 128 writes, and the last one is at base + FE00h.
- R4: While `mem_wr_en` is high and `mem_ready` is low, `mem_addr` and `mem_wdata` hold their values.
- R5: The word at slot index k (address base + FFFCh − 4k) is one of the following: slot 0 is control register 0, slot 1 is flags, slot 2 is the instruction pointer, and slots 3..10 are `snap_gpr[32(k−3) +: 32]`. Slot 11 is debug 6, slot 12 is debug 7, and every other slot is zero. All values are those present on the inputs in the cycle the request was accepted.
- R6: `ld_en` is high for exactly one cycle, in the cycle after the final write is accepted, and `done` is high for exactly the next cycle.
- R7: During `ld_en`, the outputs carry these values: CS selector 3000h, CS base 0003_0000h, data-segment selector 0 and base 0, limit FFFF_FFFFh, `ld_seg_d32` = 0, `ld_seg_expdown` = 0, flags 0000_0002h, instruction pointer 0000_8000h.
- R8: During `ld_en`, `ld_ctl0` equals the captured control register 0 with bits 31, 3, 2 and 0 cleared, and `ld_ctl4` is zero.
- R9: A request seen while `smiact` is high does not restart the sequence or recapture base or snapshot.
- R10: A synchronous `rst` returns the block to idle, so that `smiact`, `mem_wr_en`, `ld_en` and `done` are low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req | input | 1 | Pending management interrupt request |
| smm_base | input | 32 | Save-region base address |
| snap_gpr | input | 256 | Eight general-purpose registers, register k in bits 32k+31..32k |
| snap_flags | input | 32 | Flags register snapshot |
| snap_ip | input | 32 | Instruction pointer snapshot |
| snap_ctl0 | input | 32 | Control register 0 snapshot |
| snap_dbg6 | input | 32 | Debug status register snapshot |
| snap_dbg7 | input | 32 | Debug control register snapshot |
| smiact | output | 1 | Management-mode acknowledge |
| mem_wr_en | output | 1 | Save write valid |
| mem_addr | output | 32 | Save write byte address |
| mem_wdata | output | 32 | Save write data |
| mem_be | output | 4 | Save write byte enables |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| ld_en | output | 1 | Register load strobe |
| ld_cs_sel | output | 16 | Code segment selector to load |
| ld_cs_base | output | 32 | Code segment base to load |
| ld_dseg_sel | output | 16 | Selector for DS, ES, FS, GS, SS |
| ld_dseg_base | output | 32 | Base for DS, ES, FS, GS, SS |
| ld_seg_limit | output | 32 | Limit for all six segments |
| ld_seg_d32 | output | 1 | 32-bit default size attribute (0 = 16-bit) |
| ld_seg_expdown | output | 1 | Expand-down attribute (0 = expand-up) |
| ld_flags | output | 32 | Flags value to load |
| ld_ip | output | 32 | Instruction pointer to load |
| ld_ctl0 | output | 32 | Control register 0 value to load |
| ld_ctl4 | output | 32 | Control register 4 value to load |
| done | output | 1 | Entry sequence complete pulse |

## Verification
The hardest situation to reach is a save whose inputs move underneath it. This means a new request, a new base and new snapshot values arriving while writes are stalled by the memory. Only the captured copy may then appear in the write stream, and the load strobe must land exactly one cycle after the 128th accepted write. The stimulus drives a pseudo-random ready pattern and changes base and snapshot several cycles into an entry while pulsing the request again. It also holds the request high across a complete entry and resets the block partway through a save. A scoreboard queue of the expected 128 address and data pairs is compared against each accepted write.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAVE,
    ST_LOAD,
    ST_DONE
  } smm_state_e;

  localparam logic [31:0] CTL0_CLR_MASK = 32'h8000_000D;
  localparam logic [15:0] ENTRY_CS_SEL  = 16'h3000;
  localparam logic [31:0] ENTRY_CS_BASE = 32'h0003_0000;
  localparam logic [15:0] ENTRY_DS_SEL  = 16'h0000;
  localparam logic [31:0] ENTRY_DS_BASE = 32'h0000_0000;
  localparam logic [31:0] ENTRY_LIMIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] ENTRY_FLAGS   = 32'h0000_0002;
  localparam logic [31:0] ENTRY_IP      = 32'h0000_8000;
  localparam logic [31:0] ENTRY_CTL4    = 32'h0000_0000;
endpackage

// File: rtl/smm_save_agu.sv
module smm_save_agu #(
  parameter int          NUM_WORDS = 128,
  parameter int          IDX_W     = 7,
  parameter logic [31:0] TOP_OFF   = 32'h0001_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      base_in,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      addr,
  output logic             last
);
  localparam int PAD_W = 30 - IDX_W;

  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx    <= '0;
    end else if (start) begin
      base_q <= base_in;
      idx    <= '0;
    end else if (advance && !last) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign addr = base_q + TOP_OFF - 32'd4 - {{PAD_W{1'b0}}, idx, 2'b00};
  assign last = (idx == IDX_W'(NUM_WORDS - 1));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !last && !start) |=> (addr == $past(addr) - 32'd4));
endmodule

// File: rtl/smm_snap_mux.sv
module smm_snap_mux #(
  parameter int NUM_GPR   = 8,
  parameter int NUM_WORDS = 128,
  parameter int IDX_W     = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  logic [NUM_GPR*32-1:0] gpr_in,
  input  logic [31:0]           flags_in,
  input  logic [31:0]           ip_in,
  input  logic [31:0]           ctl0_in,
  input  logic [31:0]           dbg6_in,
  input  logic [31:0]           dbg7_in,
  input  logic [IDX_W-1:0]      idx,
  output logic [31:0]           word,
  output logic [31:0]           ctl0_q
);
  localparam int SLOT_GPR0 = 3;
  localparam int SLOT_DBG6 = SLOT_GPR0 + NUM_GPR;
  localparam int SLOT_DBG7 = SLOT_DBG6 + 1;

  logic [NUM_GPR*32-1:0] gpr_q;
  logic [31:0]           flags_q, ip_q, dbg6_q, dbg7_q;
  logic [31:0]           slot_w [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_q   <= '0;
      flags_q <= '0;
      ip_q    <= '0;
      ctl0_q  <= '0;
      dbg6_q  <= '0;
      dbg7_q  <= '0;
    end else if (capture) begin
      gpr_q   <= gpr_in;
      flags_q <= flags_in;
      ip_q    <= ip_in;
      ctl0_q  <= ctl0_in;
      dbg6_q  <= dbg6_in;
      dbg7_q  <= dbg7_in;
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
    if (i == 0) begin : g_ctl0
      assign slot_w[i] = ctl0_q;
    end else if (i == 1) begin : g_flags
      assign slot_w[i] = flags_q;
    end else if (i == 2) begin : g_ip
      assign slot_w[i] = ip_q;
    end else if (i >= SLOT_GPR0 && i < SLOT_DBG6) begin : g_gpr
      assign slot_w[i] = gpr_q[(i-SLOT_GPR0)*32 +: 32];
    end else if (i == SLOT_DBG6) begin : g_dbg6
      assign slot_w[i] = dbg6_q;
    end else if (i == SLOT_DBG7) begin : g_dbg7
      assign slot_w[i] = dbg7_q;
    end else begin : g_zero
      assign slot_w[i] = 32'h0;
    end
  end

  assign word = slot_w[idx];
endmodule

// File: rtl/smm_reinit.sv
module smm_reinit
  import smm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        arm,
  input  logic [31:0] ctl0_snap,
  output logic        ld_en,
  output logic        done,
  output logic [15:0] ld_cs_sel,
  output logic [31:0] ld_cs_base,
  output logic [15:0] ld_dseg_sel,
  output logic [31:0] ld_dseg_base,
  output logic [31:0] ld_seg_limit,
  output logic        ld_seg_d32,
  output logic        ld_seg_expdown,
  output logic [31:0] ld_flags,
  output logic [31:0] ld_ip,
  output logic [31:0] ld_ctl0,
  output logic [31:0] ld_ctl4
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_en          <= 1'b0;
      done           <= 1'b0;
      ld_cs_sel      <= '0;
      ld_cs_base     <= '0;
      ld_dseg_sel    <= '0;
      ld_dseg_base   <= '0;
      ld_seg_limit   <= '0;
      ld_seg_d32     <= 1'b0;
      ld_seg_expdown <= 1'b0;
      ld_flags       <= '0;
      ld_ip          <= '0;
      ld_ctl0        <= '0;
      ld_ctl4        <= '0;
    end else begin
      ld_en <= arm;
      done  <= ld_en;
      if (arm) begin
        ld_cs_sel      <= ENTRY_CS_SEL;
        ld_cs_base     <= ENTRY_CS_BASE;
        ld_dseg_sel    <= ENTRY_DS_SEL;
        ld_dseg_base   <= ENTRY_DS_BASE;
        ld_seg_limit   <= ENTRY_LIMIT;
        ld_seg_d32     <= 1'b0;
        ld_seg_expdown <= 1'b0;
        ld_flags       <= ENTRY_FLAGS;
        ld_ip          <= ENTRY_IP;
        ld_ctl0        <= ctl0_snap & ~CTL0_CLR_MASK;
        ld_ctl4        <= ENTRY_CTL4;
      end
    end
  end

  // R8
  ctl0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> ((ld_ctl0 & CTL0_CLR_MASK) == 32'h0));
endmodule

// File: rtl/smm_entry_seq.sv
module smm_entry_seq
  import smm_pkg::*;
#(
  parameter int          NUM_GPR      = 8,
  parameter int          REGION_BYTES = 512,
  parameter logic [31:0] TOP_OFF      = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smi_req,
  input  logic [31:0]           smm_base,
  input  logic [NUM_GPR*32-1:0] snap_gpr,
  input  logic [31:0]           snap_flags,
  input  logic [31:0]           snap_ip,
  input  logic [31:0]           snap_ctl0,
  input  logic [31:0]           snap_dbg6,
  input  logic [31:0]           snap_dbg7,
  output logic                  smiact,
  output logic                  mem_wr_en,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  output logic [3:0]            mem_be,
  input  logic                  mem_ready,
  output logic                  ld_en,
  output logic [15:0]           ld_cs_sel,
  output logic [31:0]           ld_cs_base,
  output logic [15:0]           ld_dseg_sel,
  output logic [31:0]           ld_dseg_base,
  output logic [31:0]           ld_seg_limit,
  output logic                  ld_seg_d32,
  output logic                  ld_seg_expdown,
  output logic [31:0]           ld_flags,
  output logic [31:0]           ld_ip,
  output logic [31:0]           ld_ctl0,
  output logic [31:0]           ld_ctl4,
  output logic                  done
);
  localparam int NUM_WORDS = REGION_BYTES / 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  smm_state_e       state;
  logic             start, accept, final_acc, last;
  logic [IDX_W-1:0] idx;
  logic [31:0]      ctl0_q;

  assign start     = (state == ST_IDLE) && smi_req;
  assign accept    = (state == ST_SAVE) && mem_ready;
  assign final_acc = accept && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (smi_req) state <= ST_SAVE;
        ST_SAVE: if (final_acc) state <= ST_LOAD;
        ST_LOAD: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign smiact    = (state != ST_IDLE);
  assign mem_wr_en = (state == ST_SAVE);
  assign mem_be    = 4'hF;

  smm_save_agu #(
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W),
    .TOP_OFF  (TOP_OFF)
  ) u_agu (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .base_in(smm_base),
    .advance(accept),
    .idx    (idx),
    .addr   (mem_addr),
    .last   (last)
  );

  smm_snap_mux #(
    .NUM_GPR  (NUM_GPR),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_mux (
    .clk     (clk),
    .rst     (rst),
    .capture (start),
    .gpr_in  (snap_gpr),
    .flags_in(snap_flags),
    .ip_in   (snap_ip),
    .ctl0_in (snap_ctl0),
    .dbg6_in (snap_dbg6),
    .dbg7_in (snap_dbg7),
    .idx     (idx),
    .word    (mem_wdata),
    .ctl0_q  (ctl0_q)
  );

  smm_reinit u_reinit (
    .clk           (clk),
    .rst           (rst),
    .arm           (final_acc),
    .ctl0_snap     (ctl0_q),
    .ld_en         (ld_en),
    .done          (done),
    .ld_cs_sel     (ld_cs_sel),
    .ld_cs_base    (ld_cs_base),
    .ld_dseg_sel   (ld_dseg_sel),
    .ld_dseg_base  (ld_dseg_base),
    .ld_seg_limit  (ld_seg_limit),
    .ld_seg_d32    (ld_seg_d32),
    .ld_seg_expdown(ld_seg_expdown),
    .ld_flags      (ld_flags),
    .ld_ip         (ld_ip),
    .ld_ctl0       (ld_ctl0),
    .ld_ctl4       (ld_ctl4)
  );

  // R6
  ld_single_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (!ld_en && done));
  // R6
  ld_after_save_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> (state == ST_LOAD));
  // R1
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smiact && !done) |=> smiact);
  // R1
  act_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !smiact);
  // R2
  be_full_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_be == 4'hF));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && !mem_ready && smi_req) |=> $stable(mem_addr));
endmodule

// File: tb/smm_entry_seq_bench.sv
module smm_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smi_req = 1'b0;
  logic [31:0]  smm_base = '0;
  logic [255:0] snap_gpr = '0;
  logic [31:0]  snap_flags = '0, snap_ip = '0, snap_ctl0 = '0, snap_dbg6 = '0, snap_dbg7 = '0;
  logic         smiact, mem_wr_en, mem_ready, ld_en, done;
  logic [31:0]  mem_addr, mem_wdata;
  logic [3:0]   mem_be;
  logic [15:0]  ld_cs_sel, ld_dseg_sel;
  logic [31:0]  ld_cs_base, ld_dseg_base, ld_seg_limit, ld_flags, ld_ip, ld_ctl0, ld_ctl4;
  logic         ld_seg_d32, ld_seg_expdown;

  smm_entry_seq u_smm_entry_seq (
    .clk(clk), .rst(rst), .smi_req(smi_req), .smm_base(smm_base),
    .snap_gpr(snap_gpr), .snap_flags(snap_flags), .snap_ip(snap_ip),
    .snap_ctl0(snap_ctl0), .snap_dbg6(snap_dbg6), .snap_dbg7(snap_dbg7),
    .smiact(smiact), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
    .ld_en(ld_en), .ld_cs_sel(ld_cs_sel), .ld_cs_base(ld_cs_base),
    .ld_dseg_sel(ld_dseg_sel), .ld_dseg_base(ld_dseg_base),
    .ld_seg_limit(ld_seg_limit), .ld_seg_d32(ld_seg_d32),
    .ld_seg_expdown(ld_seg_expdown), .ld_flags(ld_flags), .ld_ip(ld_ip),
    .ld_ctl0(ld_ctl0), .ld_ctl4(ld_ctl4), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] exp_q [$];
  logic [31:0] exp_ctl0 = '0;
  bit   ready_rand = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  bit   done_seen = 1'b0;
  int   ld_count = 0;
  bit   prev_stall = 0, prev_final = 0, prev_ld = 0, prev_done = 0;
  logic [31:0] prev_addr = '0, prev_data = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] slot_word(input int k, input logic [255:0] g,
      input logic [31:0] fl, input logic [31:0] ip, input logic [31:0] c0,
      input logic [31:0] d6, input logic [31:0] d7);
    if (k == 0) return c0;
    if (k == 1) return fl;
    if (k == 2) return ip;
    if (k >= 3 && k <= 10) return g[(k-3)*32 +: 32];
    if (k == 11) return d6;
    if (k == 12) return d7;
    return 32'h0;
  endfunction

  // driver: loads inputs and pushes the expected write stream
  task automatic set_entry(input logic [31:0] base, input logic [31:0] seed);
    smm_base   = base;
    for (int i = 0; i < 8; i++) snap_gpr[i*32 +: 32] = seed ^ (32'h1111_0000 * (i + 1)) ^ i;
    snap_flags = seed ^ 32'h0000_0246;
    snap_ip    = seed ^ 32'h0040_1000;
    snap_ctl0  = seed | 32'h8000_0011;
    snap_dbg6  = seed ^ 32'hFFFF_0FF0;
    snap_dbg7  = seed ^ 32'h0000_0400;
    exp_q.delete();
    for (int k = 0; k < NWORDS; k++)
      exp_q.push_back({base + 32'hFFFC - 32'(4*k),
        slot_word(k, snap_gpr, snap_flags, snap_ip, snap_ctl0, snap_dbg6, snap_dbg7)});
    exp_ctl0  = snap_ctl0 & ~32'h8000_000D;
    done_seen = 1'b0;
    ld_count  = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    mem_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    if (rst) begin
      prev_stall = 0; prev_final = 0; prev_ld = 0; prev_done = 0;
    end else begin
      if (mem_wr_en || ld_en || done)
        chk(smiact, "R1 smiact during sequence", {63'b0, smiact}, 64'd1);
      if (prev_done)
        chk(!smiact, "R1 smiact after done", {63'b0, smiact}, 64'd0);
      if (prev_stall)
        chk(mem_wr_en && mem_addr == prev_addr && mem_wdata == prev_data, "R4 stall hold",
            {mem_addr, mem_wdata}, {prev_addr, prev_data});
      if (mem_wr_en && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected write", {mem_addr, mem_wdata}, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(mem_be == 4'hF, "R2 byte enables", {60'b0, mem_be}, 64'hF);
          chk(mem_addr == e[63:32], "R2 R3 address", {32'b0, mem_addr}, {32'b0, e[63:32]});
          chk(mem_wdata == e[31:0], "R5 data", {32'b0, mem_wdata}, {32'b0, e[31:0]});
        end
      end
      chk(ld_en == prev_final, "R6 load after final write", {63'b0, ld_en}, {63'b0, prev_final});
      chk(done == prev_ld, "R6 done after load", {63'b0, done}, {63'b0, prev_ld});
      if (ld_en) begin
        ld_count++;
        chk(ld_cs_sel == 16'h3000 && ld_cs_base == 32'h0003_0000, "R7 code segment",
            {ld_cs_sel, ld_cs_base}, {16'h3000, 32'h0003_0000});
        chk(ld_dseg_sel == 16'h0 && ld_dseg_base == 32'h0 && ld_seg_limit == 32'hFFFF_FFFF,
            "R7 data segments", {ld_dseg_sel, ld_seg_limit}, {16'h0, 32'hFFFF_FFFF});
        chk(!ld_seg_d32 && !ld_seg_expdown, "R7 attributes",
            {62'b0, ld_seg_d32, ld_seg_expdown}, 64'd0);
        chk(ld_flags == 32'h2 && ld_ip == 32'h8000, "R7 flags ip",
            {ld_flags, ld_ip}, {32'h2, 32'h8000});
        chk(ld_ctl0 == exp_ctl0, "R8 ctl0", {32'b0, ld_ctl0}, {32'b0, exp_ctl0});
        chk(ld_ctl4 == 32'h0, "R8 ctl4", {32'b0, ld_ctl4}, 64'd0);
      end
      if (done) done_seen = 1'b1;
      prev_final = mem_wr_en && mem_ready && (exp_q.size() == 0);
      prev_stall = mem_wr_en && !mem_ready;
      prev_addr  = mem_addr;
      prev_data  = mem_wdata;
      prev_ld    = ld_en;
      prev_done  = done;
    end
  end

  task automatic pulse_req();
    @(negedge clk); smi_req = 1'b1;
    @(negedge clk); smi_req = 1'b0;
  endtask

  task automatic wait_done();
    wait (done_seen);
    repeat (3) @(negedge clk);
    #2;
    chk(!smiact && !mem_wr_en, "R1 idle after entry", {62'b0, smiact, mem_wr_en}, 64'd0);
    chk(exp_q.size() == 0, "R3 all 128 words written", 64'(exp_q.size()), 64'd0);
    chk(ld_count == 1, "R6 single load strobe", 64'(ld_count), 64'd1);
  endtask

  bit wd_hit = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!smiact && !mem_wr_en && !ld_en && !done, "R10 reset state",
        {60'b0, smiact, mem_wr_en, ld_en, done}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // entry 1: random ready, inputs disturbed mid-save (R5, R9)
    ready_rand = 1'b1;
    set_entry(32'h0003_0000, 32'hA5A5_0001);
    pulse_req();
    repeat (6) @(negedge clk);
    smm_base = 32'h0077_0000; snap_ctl0 = 32'h0; snap_flags = 32'hDEAD_BEEF;
    snap_gpr = {8{32'h1234_5678}};
    smi_req = 1'b1;
    repeat (3) @(negedge clk);
    smi_req = 1'b0;
    fork
      begin wait_done(); end
      begin wait (wd_hit); end
    join_any
    disable fork;

    // entry 2: request held high through the whole entry (R9), full-speed ready
    ready_rand = 1'b0;
    set_entry(32'h000A_0000, 32'h0F0F_7777);
    @(negedge clk); smi_req = 1'b1;
    fork
      begin wait (done_seen); smi_req = 1'b0; wait_done(); end
      begin wait (wd_hit); end
    join_any
    disable fork;
    smi_req = 1'b0;

    // entry 3: reset in the middle of a save (R10)
    ready_rand = 1'b1;
    set_entry(32'h0010_0000, 32'h3333_3333);
    pulse_req();
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #2;
    chk(!smiact && !mem_wr_en && !ld_en && !done, "R10 reset mid-save",
        {60'b0, smiact, mem_wr_en, ld_en, done}, 64'd0);
    exp_q.delete();
    @(negedge clk); rst = 1'b0;

    // entry 4: all control register 0 bits set (R8), after reset
    set_entry(32'hFFF0_0000, 32'hFFFF_FFFF);
    pulse_req();
    fork
      begin wait_done(); end
      begin wait (wd_hit); end
    join_any
    disable fork;

    if (wd_hit) chk(1'b0, "watchdog", 64'd1, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule